// File: doc/BRIEF.md
# Streaming Payload XOR Cipher Stage

This stage sits in a packet datapath, after the port-lookup step and before the output queues. Packets arrive as 64-bit words with an 8-bit control side-band. Words with a nonzero control value that come before the first zero-control word are internal module headers. They pass through untouched. The first zero-control word is the first word of packet data. The Ethernet header (14 bytes) and the option-free IPv4 header (20 bytes) leave as plaintext. Every packet byte after those 34 bytes is XORed with a 32-bit key that software has loaded.

XOR undoes itself, so one instance with the same key encrypts on one side and decrypts on the other. The 34-byte boundary falls inside the fifth data word, so that word is split by byte. A small fall-through FIFO decouples the stage from the module upstream. Words leave the stage only when the downstream module is ready, and the output is registered.

Top module: `payload_xor_stage`

## Requirements
- R1: Any word with nonzero `in_ctrl` that arrives before the first zero-control word of a packet is forwarded with its data and control unchanged.
- R2: Packet bytes 0 to 33 (0-based) are forwarded unchanged. Byte 0 is bits [63:56] of the first zero-control word, and byte k of a word sits in bits [63-8k -: 8].
- R3: Every packet byte at index p >= 34 is XORed with key byte (p-34) mod 4. Key byte 0 is bits [31:24] of the key. In the fifth data word only lanes 2 to 7 are XORed. This rule also covers pad bytes in the last word.
- R4: `out_ctrl` always equals the control value of the word it carries. A nonzero control value after packet data ends the packet, and the words that follow are treated as module headers of a new packet.
- R5: A packet that was transformed with a key and is fed in again with the same key comes out as the original packet.
- R6: A key write through `key_wr`/`key_wdata` takes effect from the packet whose first data word leaves the FIFO after the write. A packet already in flight keeps the key it started with.
- R7: Under any pattern of `out_rdy`, every accepted word leaves exactly once and in order.
- R8: `out_wr` is high only in a cycle that follows a cycle with `out_rdy` high. After reset, `out_wr` is low.
- R9: `in_rdy` is high after reset and goes low once the FIFO holds FIFO_DEPTH words. A write offered while `in_rdy` is low is not stored.
- R10: A packet that ends before byte 34 passes through with no byte changed, and the next packet is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Incoming word |
| in_ctrl | input | 8 | Incoming control side-band |
| in_wr | input | 1 | Incoming word valid |
| in_rdy | output | 1 | Stage can take a word |
| out_data | output | 64 | Outgoing word |
| out_ctrl | output | 8 | Outgoing control side-band |
| out_wr | output | 1 | Outgoing word valid |
| out_rdy | input | 1 | Downstream can take a word next cycle |
| key_wr | input | 1 | Key write strobe |
| key_wdata | input | 32 | Key value to store |

## Verification
If the word-position state is wrong, the error shows up in the first word that leaves the stage after the fault. A machine stuck in header-skip emits plaintext payload. One that misses a packet end encrypts the next packet's headers. A split-lane error corrupts exactly bytes 32 to 39. A fault in key capture appears only at the following packet, as a whole packet XORed with the wrong rotated key. FIFO pointer or handshake faults appear as lost, repeated or reordered words, which the scoreboard catches at the next output word.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    ST_MODHDR  = 2'd0,
    ST_NETHDR  = 2'd1,
    ST_SPLIT   = 2'd2,
    ST_PAYLOAD = 2'd3
  } pxc_state_e;
endpackage

// File: rtl/pxc_fifo.sv
module pxc_fifo #(
  parameter int W     = 72,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         not_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  assign empty    = (cnt == '0);
  assign not_full = (cnt != FULL_CNT);
  assign push_ok  = push && not_full;
  assign pop_ok   = pop && !empty;
  assign dout     = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !not_full) |=> cnt == $past(cnt));

  // R9
  fill_track_chk: assert property (@(posedge clk) disable iff (rst)
    (push && not_full && !pop) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/pxc_seq.sv
module pxc_seq
  import pxc_pkg::*;
#(
  parameter int NB         = 8,
  parameter int SPLIT_W    = 4,
  parameter int SPLIT_LANE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  logic          ctrl_zero,
  output logic [NB-1:0] lane_en,
  output logic          pkt_start
);
  localparam int CNT_W = $clog2(SPLIT_W + 1);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(SPLIT_W - 1);

  pxc_state_e st;
  logic [CNT_W-1:0] wcnt;

  always_comb begin
    pkt_start = xfer && ctrl_zero && (st == ST_MODHDR);
    for (int l = 0; l < NB; l++) begin
      case (st)
        ST_SPLIT:   lane_en[l] = (l >= SPLIT_LANE);
        ST_PAYLOAD: lane_en[l] = 1'b1;
        default:    lane_en[l] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_MODHDR;
      wcnt <= '0;
    end else if (xfer) begin
      case (st)
        ST_MODHDR: if (ctrl_zero) begin
          st   <= ST_NETHDR;
          wcnt <= CNT_W'(1);
        end
        ST_NETHDR: begin
          if (!ctrl_zero)            st <= ST_MODHDR;
          else if (wcnt == LAST_HDR) st <= ST_SPLIT;
          wcnt <= wcnt + 1'b1;
        end
        ST_SPLIT:   st <= ctrl_zero ? ST_PAYLOAD : ST_MODHDR;
        ST_PAYLOAD: if (!ctrl_zero) st <= ST_MODHDR;
        default:    st <= ST_MODHDR;
      endcase
    end
  end

  // R3
  split_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SPLIT && $past(st) != ST_SPLIT) |-> $past(st) == ST_NETHDR);

  // R4
  end_return_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !ctrl_zero && st != ST_MODHDR) |=> st == ST_MODHDR);
endmodule

// File: rtl/pxc_keyreg.sv
module pxc_keyreg #(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             pkt_start,
  output logic [KEY_W-1:0] key_act
);
  logic [KEY_W-1:0] key_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_stage <= '0;
      key_act   <= '0;
    end else begin
      if (key_wr) key_stage <= key_wdata;
      if (pkt_start) key_act <= key_wr ? key_wdata : key_stage;
    end
  end

  // R6
  key_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (key_act != $past(key_act)) |-> $past(pkt_start));
endmodule

// File: rtl/payload_xor_stage.sv
module payload_xor_stage #(
  parameter int DATA_W       = 64,
  parameter int CTRL_W       = 8,
  parameter int KEY_W        = 32,
  parameter int FIFO_DEPTH   = 4,
  parameter int CIPHER_START = 34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              in_wr,
  output logic              in_rdy,
  output logic [DATA_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              out_wr,
  input  logic              out_rdy,
  input  logic              key_wr,
  input  logic [KEY_W-1:0]  key_wdata
);
  localparam int NB         = DATA_W / 8;
  localparam int KB         = KEY_W / 8;
  localparam int SPLIT_W    = CIPHER_START / NB;
  localparam int SPLIT_LANE = CIPHER_START % NB;
  localparam int KROT       = KB - (CIPHER_START % KB);
  localparam int FW         = DATA_W + CTRL_W;

  logic [FW-1:0]     head;
  logic [DATA_W-1:0] head_data;
  logic [CTRL_W-1:0] head_ctrl;
  logic              fifo_empty, xfer, pkt_start;
  logic [NB-1:0]     lane_en;
  logic [KEY_W-1:0]  key_act;
  logic [DATA_W-1:0] kvec, kmask;

  assign head_data = head[FW-1:CTRL_W];
  assign head_ctrl = head[CTRL_W-1:0];
  assign xfer      = !fifo_empty && out_rdy;

  pxc_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(in_wr), .din({in_data, in_ctrl}),
    .pop(xfer), .dout(head), .empty(fifo_empty), .not_full(in_rdy)
  );

  pxc_seq #(.NB(NB), .SPLIT_W(SPLIT_W), .SPLIT_LANE(SPLIT_LANE)) u_seq (
    .clk(clk), .rst(rst), .xfer(xfer), .ctrl_zero(head_ctrl == '0),
    .lane_en(lane_en), .pkt_start(pkt_start)
  );

  pxc_keyreg #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_wdata(key_wdata),
    .pkt_start(pkt_start), .key_act(key_act)
  );

  for (genvar l = 0; l < NB; l++) begin : g_lane
    localparam int KIDX = (l + KROT) % KB;
    assign kvec[DATA_W-1-8*l -: 8]  = key_act[KEY_W-1-8*KIDX -: 8];
    assign kmask[DATA_W-1-8*l -: 8] = {8{lane_en[l]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wr   <= 1'b0;
      out_data <= '0;
      out_ctrl <= '0;
    end else begin
      out_wr <= xfer;
      if (xfer) begin
        out_data <= head_data ^ (kvec & kmask);
        out_ctrl <= head_ctrl;
      end
    end
  end

  // R8
  wr_after_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> $past(out_rdy));

  // R4
  ctrl_pass_chk: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> out_ctrl == $past(head_ctrl));

  // R1 R2
  plain_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (out_wr && $past(lane_en) == '0) |-> out_data == $past(head_data));
endmodule

// File: tb/sim_payload_xor_stage.sv
module sim_payload_xor_stage;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_wr = 1'b0;
  logic        in_rdy;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic        out_wr;
  logic        out_rdy = 1'b1;
  logic        key_wr = 1'b0;
  logic [31:0] key_wdata = '0;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;
  int cyc = 0;
  logic rdy_at_edge = 1'b0;
  logic [31:0] staged_key = '0;

  logic [71:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  payload_xor_stage u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr),
    .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr),
    .out_rdy(out_rdy), .key_wr(key_wr), .key_wdata(key_wdata)
  );

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rdy_at_edge <= out_rdy;
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0:       out_rdy = 1'b1;
      1:       out_rdy = (cyc % 3 != 0) && (cyc % 7 != 2);
      default: out_rdy = 1'b0;
    endcase
  end

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && out_wr) begin
      // R8
      check(rdy_at_edge, "R8", {71'd0, out_wr}, {71'd0, 1'b1});
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", {out_data, out_ctrl}, '0);
      end else begin
        logic [71:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e[71:8], t, {out_data, out_ctrl}, e);
        check(out_ctrl == e[7:0], "R4", {out_data, out_ctrl}, e);
      end
    end
  end

  task automatic push_word(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    while (!in_rdy) begin
      in_wr = 1'b0;
      @(negedge clk);
    end
    in_wr = 1'b1;
    in_data = d;
    in_ctrl = c;
  endtask

  task automatic idle();
    @(negedge clk);
    in_wr = 1'b0;
  endtask

  task automatic write_key(input logic [31:0] k);
    @(negedge clk);
    in_wr = 1'b0;
    key_wr = 1'b1;
    key_wdata = k;
    staged_key = k;
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  // nmod module headers, nbytes packet bytes; twice: feed ciphertext, expect plaintext
  task automatic send_pkt(input int nmod, input int nbytes, input int seed,
                          input bit twice, input string tag,
                          input int mid_w, input logic [31:0] mid_key);
    int nw;
    logic [31:0] k;
    logic [7:0] plain[], ciph[];
    nw = (nbytes + 7) / 8;
    k = staged_key;
    plain = new[nw*8];
    ciph  = new[nw*8];
    for (int i = 0; i < nw*8; i++) begin
      plain[i] = 8'(seed * 7 + i * 13 + (i >> 3));
      ciph[i]  = (i >= 34) ? plain[i] ^ k[31-8*((i-34)%4) -: 8] : plain[i];
    end
    for (int m = 0; m < nmod; m++) begin
      logic [63:0] d;
      logic [7:0]  c;
      d = {32'(seed), 32'(m) ^ 32'hDEAD0000};
      c = 8'hF0 | 8'(m + 1);
      exp_q.push_back({d, c});
      tag_q.push_back("R1");
      push_word(d, c);
    end
    for (int w = 0; w < nw; w++) begin
      logic [63:0] din, dex;
      logic [7:0]  c;
      string t;
      for (int l = 0; l < 8; l++) begin
        din[63-8*l -: 8] = twice ? ciph[8*w+l] : plain[8*w+l];
        dex[63-8*l -: 8] = twice ? plain[8*w+l] : ciph[8*w+l];
      end
      c = (w == nw - 1) ? 8'(8'h01 << ((nbytes - 1) % 8)) : 8'h00;
      if (tag != "") t = tag;
      else if (twice) t = "R5";
      else if (w < 4) t = "R2";
      else t = "R3";
      exp_q.push_back({dex, c});
      tag_q.push_back(t);
      push_word(din, c);
      if (w == mid_w) write_key(mid_key);
    end
    idle();
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    // R7: nothing lost
    check(exp_q.size() == 0, "R7", 72'(exp_q.size()), 72'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 R9 reset state
    check(out_wr == 1'b0, "R8", {71'd0, out_wr}, 72'd0);
    check(in_rdy == 1'b1, "R9", {71'd0, in_rdy}, 72'd1);

    write_key(32'hA5C3_0F96);
    send_pkt(2, 64, 1, 1'b0, "", -1, '0);
    send_pkt(0, 41, 2, 1'b0, "", -1, '0);
    send_pkt(1, 40, 3, 1'b0, "", -1, '0);
    // R10 short packet, then a normal one
    send_pkt(1, 20, 4, 1'b0, "R10", -1, '0);
    send_pkt(1, 48, 5, 1'b0, "", -1, '0);
    drain();

    // R7 backpressure
    rdy_mode = 1;
    send_pkt(3, 100, 6, 1'b0, "R7", -1, '0);
    send_pkt(0, 57, 7, 1'b0, "R7", -1, '0);
    drain();
    rdy_mode = 0;

    // R6 key write mid packet: current packet keeps old key
    send_pkt(1, 80, 8, 1'b0, "R6", 6, 32'h1234_5678);
    send_pkt(2, 72, 9, 1'b0, "R6", -1, '0);
    drain();

    // R5 round trip
    send_pkt(1, 90, 10, 1'b1, "", -1, '0);
    drain();

    // R9 FIFO fills while downstream stalls
    rdy_mode = 2;
    fork
      send_pkt(1, 64, 11, 1'b0, "", -1, '0);
      begin
        repeat (12) @(negedge clk);
        check(in_rdy == 1'b0, "R9", {71'd0, in_rdy}, 72'd0);
        check(out_wr == 1'b0, "R8", {71'd0, out_wr}, 72'd0);
        rdy_mode = 0;
      end
    join
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule